// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular window of in-flight instruction slots. An instruction that enters execution claims the slot at the tail, and the slot's index becomes the instruction's result tag. Execution units finish in any order and post their results, tagged by slot, onto a single result bus. Until a result retires, its slot acts as an extra rename register: a consumer can look up a tag and pick up the finished value.

Retirement happens only at the oldest slot, the head, and only once its result has arrived. A register-kind slot produces a register-file write. A store-kind slot produces a memory write whose address is the slot's destination field. Any other kind simply frees its slot. A slot whose result came back with a fault flag is not retired. When it reaches the head, the block signals the fault and discards the whole window. An external flush, raised for example after a wrong branch guess, discards the window in the same way. Because of these two rules, no younger instruction ever reaches architectural state.

Top module: `rob_top`

## Requirements
- R1: After reset the window is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `cm_valid`, `cm_reg_we`, `cm_mem_we`, `exc_take` and `lk_hit` are all 0.
- R2: Each accepted claim returns the tail index on `alloc_tag` in the same cycle. Successive claims return consecutive indices that wrap from DEPTH-1 back to 0.
- R3: When DEPTH slots are occupied, `alloc_ready` is 0 and a raised `alloc_valid` claims nothing and overwrites nothing.
- R4: A result write marks an occupied slot finished with the posted value. A result write to an unoccupied slot is ignored: a later claim of that slot starts out unfinished.
- R5: A lookup of tag t reports `lk_hit`=1 with the stored value exactly when slot t is occupied and finished. Otherwise `lk_hit` is 0 and `lk_value` is 0.
- R6: Nothing retires while the head slot is unfinished, even if younger slots are finished. Retirement follows claim order, at most one slot per cycle.
- R7: A retiring slot drives `cm_tag`, `cm_dest` and `cm_value`. Kind code 0 (register) raises `cm_reg_we`, kind code 1 (store) raises `cm_mem_we`, and kinds 2 and 3 raise neither but still free the slot.
- R8: A claim and a retirement in the same cycle leave the occupancy unchanged.
- R9: `flush` empties the window on the next edge and resets both pointers, so the next claim gets tag 0. In the flush cycle, any retirement is masked and any claim is dropped.
- R10: A finished head slot carrying a fault raises `exc_take` with its tag on `cm_tag`, raises no write and no `cm_valid`, drops any claim in that cycle, and empties the window with both pointers at 0.
- R11: A fault in a slot that is not the head has no effect until that slot is the head. Older slots retire normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request to claim the tail slot |
| alloc_kind | input | 2 | 0 register, 1 store, 2/3 no state write |
| alloc_dest | input | DEST_W | Register number or store address |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | TAG_W | Index of the slot being claimed |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_exc | input | 1 | Result carries a fault |
| lk_tag | input | TAG_W | Slot being looked up |
| lk_hit | output | 1 | Looked-up slot holds a finished value |
| lk_value | output | DATA_W | Finished value, 0 when no hit |
| flush | input | 1 | Discard all slots |
| cm_valid | output | 1 | Head slot retires this cycle |
| cm_reg_we | output | 1 | Register-file write from the head |
| cm_mem_we | output | 1 | Memory write from the head |
| cm_tag | output | TAG_W | Index of the head slot |
| cm_dest | output | DEST_W | Destination of the head slot |
| cm_value | output | DATA_W | Value of the head slot |
| exc_take | output | 1 | Head fault taken; window discarded |

## Verification
Two pairs of events can meet in one cycle. A claim can coincide with a retirement, and a flush or a head fault can coincide with a claim or a ready retirement. The bench retires the head in the same cycle that it claims a new slot, then keeps claiming until `alloc_ready` drops. It judges the accepted count against DEPTH minus the one surviving slot. It also raises flush while the head is finished and a claim is pending, then expects no write outputs in that cycle and tag 0 on the following claim.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    K_REG   = 2'd0,
    K_STORE = 2'd1,
    K_OTHER = 2'd2
  } rob_kind_e;

  // Circular successor of a slot index.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one optional claim and one optional retirement.
  function automatic int unsigned next_fill(int unsigned fill, logic add, logic sub);
    return fill + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_alloc,
  input  logic             do_retire,
  input  logic             clear,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full
);

  logic [CNT_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      head   <= '0;
      tail   <= '0;
      fill_q <= '0;
    end else begin
      if (do_alloc)  tail <= TAG_W'(wrap_inc(int'(tail), DEPTH));
      if (do_retire) head <= TAG_W'(wrap_inc(int'(head), DEPTH));
      fill_q <= CNT_W'(next_fill(int'(fill_q), do_alloc, do_retire));
    end
  end

  assign full = (fill_q == CNT_W'(DEPTH));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));

  a_r3_no_claim_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !do_alloc);

  a_r8_claim_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && do_retire && !clear) |=> fill_q == $past(fill_q));

  a_r2_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !clear) |=> tail == TAG_W'(wrap_inc(int'($past(tail)), DEPTH)));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == '0 && head == '0 && tail == '0));

endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         alloc_we,
  input  logic [TAG_W-1:0]             alloc_idx,
  input  logic [1:0]                   alloc_kind,
  input  logic [DEST_W-1:0]            alloc_dest,
  input  logic                         wb_we,
  input  logic [TAG_W-1:0]             wb_idx,
  input  logic [DATA_W-1:0]            wb_value,
  input  logic                         wb_exc,
  input  logic                         retire_we,
  input  logic [TAG_W-1:0]             retire_idx,
  output logic [DEPTH-1:0]             s_valid,
  output logic [DEPTH-1:0]             s_done,
  output logic [DEPTH-1:0]             s_exc,
  output logic [DEPTH-1:0][1:0]        s_kind,
  output logic [DEPTH-1:0][DEST_W-1:0] s_dest,
  output logic [DEPTH-1:0][DATA_W-1:0] s_value
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic claim_here, post_here, free_here;
    assign claim_here = alloc_we  && (alloc_idx  == TAG_W'(i));
    assign post_here  = wb_we     && (wb_idx     == TAG_W'(i)) && s_valid[i];
    assign free_here  = retire_we && (retire_idx == TAG_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        s_valid[i] <= 1'b0;
        s_done[i]  <= 1'b0;
        s_exc[i]   <= 1'b0;
        s_kind[i]  <= 2'd0;
        s_dest[i]  <= '0;
        s_value[i] <= '0;
      end else begin
        if (claim_here) begin
          s_valid[i] <= 1'b1;
          s_done[i]  <= 1'b0;
          s_exc[i]   <= 1'b0;
          s_kind[i]  <= alloc_kind;
          s_dest[i]  <= alloc_dest;
        end else if (post_here) begin
          s_done[i]  <= 1'b1;
          s_exc[i]   <= wb_exc;
          s_value[i] <= wb_value;
        end
        if (free_here) s_valid[i] <= 1'b0;
      end
    end
  end

  a_r4_post_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && s_valid[wb_idx] && !clear && !(retire_we && retire_idx == wb_idx))
      |=> s_done[$past(wb_idx)]);

  a_r4_claim_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_we && !clear) |=> (s_valid[$past(alloc_idx)] && !s_done[$past(alloc_idx)]));

endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic [DEPTH-1:0]             s_valid,
  input  logic [DEPTH-1:0]             s_done,
  input  logic [DEPTH-1:0][DATA_W-1:0] s_value,
  output logic                         lk_hit,
  output logic [DATA_W-1:0]            lk_value
);

  always_comb begin
    lk_hit   = s_valid[lk_tag] && s_done[lk_tag];
    lk_value = lk_hit ? s_value[lk_tag] : '0;
  end

endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_exc,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_value,
  input  logic              flush,
  output logic              cm_valid,
  output logic              cm_reg_we,
  output logic              cm_mem_we,
  output logic [TAG_W-1:0]  cm_tag,
  output logic [DEST_W-1:0] cm_dest,
  output logic [DATA_W-1:0] cm_value,
  output logic              exc_take
);

  logic [TAG_W-1:0]             head, tail;
  logic                         full;
  logic [DEPTH-1:0]             s_valid, s_done, s_exc;
  logic [DEPTH-1:0][1:0]        s_kind;
  logic [DEPTH-1:0][DEST_W-1:0] s_dest;
  logic [DEPTH-1:0][DATA_W-1:0] s_value;

  // Named internal events.
  logic head_ready, head_fire, do_alloc, do_retire, clear;

  assign head_ready = s_valid[head] && s_done[head];
  assign head_fire  = head_ready && !flush;
  assign exc_take   = head_fire && s_exc[head];
  assign do_retire  = head_fire && !s_exc[head];
  assign clear      = flush || exc_take;
  assign do_alloc   = alloc_valid && !full && !clear;

  assign alloc_ready = !full;
  assign alloc_tag   = tail;

  assign cm_valid  = do_retire;
  assign cm_reg_we = do_retire && (s_kind[head] == K_REG);
  assign cm_mem_we = do_retire && (s_kind[head] == K_STORE);
  assign cm_tag    = head;
  assign cm_dest   = s_dest[head];
  assign cm_value  = s_value[head];

  rob_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .do_alloc(do_alloc), .do_retire(do_retire),
    .clear(clear), .head(head), .tail(tail), .full(full)
  );

  rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) i_slots (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .alloc_we(do_alloc), .alloc_idx(tail), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .wb_we(wb_valid), .wb_idx(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
    .retire_we(do_retire), .retire_idx(head),
    .s_valid(s_valid), .s_done(s_done), .s_exc(s_exc),
    .s_kind(s_kind), .s_dest(s_dest), .s_value(s_value)
  );

  rob_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_lookup (
    .lk_tag(lk_tag), .s_valid(s_valid), .s_done(s_done), .s_value(s_value),
    .lk_hit(lk_hit), .lk_value(lk_value)
  );

  a_r6_retire_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid || exc_take) |-> (s_valid[cm_tag] && s_done[cm_tag]));

  a_r6_retire_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> (cm_tag == TAG_W'(wrap_inc(int'($past(cm_tag)), DEPTH))));

  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_reg_we && cm_mem_we));

  a_r10_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> !(cm_reg_we || cm_mem_we || cm_valid));

  a_r9_flush_masks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(cm_valid || exc_take));

endmodule

// File: tb/test_rob_top.sv
module test_rob_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int DEST_W = 32;
  localparam int TAG_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid; logic [1:0] alloc_kind; logic [DEST_W-1:0] alloc_dest;
  logic alloc_ready; logic [TAG_W-1:0] alloc_tag;
  logic wb_valid; logic [TAG_W-1:0] wb_tag; logic [DATA_W-1:0] wb_value; logic wb_exc;
  logic [TAG_W-1:0] lk_tag; logic lk_hit; logic [DATA_W-1:0] lk_value;
  logic flush;
  logic cm_valid, cm_reg_we, cm_mem_we, exc_take;
  logic [TAG_W-1:0] cm_tag; logic [DEST_W-1:0] cm_dest; logic [DATA_W-1:0] cm_value;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) i_rob_top (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
    .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_value(lk_value),
    .flush(flush),
    .cm_valid(cm_valid), .cm_reg_we(cm_reg_we), .cm_mem_we(cm_mem_we),
    .cm_tag(cm_tag), .cm_dest(cm_dest), .cm_value(cm_value), .exc_take(exc_take)
  );

  function automatic logic [DATA_W-1:0] val_of(int i);
    return DATA_W'(32'hA000_0000 + i * 17);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_kind = 0; alloc_dest = 0;
    wb_valid = 0; wb_tag = 0; wb_value = 0; wb_exc = 0;
    lk_tag = 0; flush = 0;
  endtask

  task automatic nxt();
    @(posedge clk); #1; idle();
  endtask

  task automatic run();
    int n_acc;
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "retire outputs", {cm_valid, cm_reg_we, cm_mem_we, exc_take}, 0);
    chk("R1", "lk_hit", lk_hit, 0);
    nxt();

    // Fill the window; kinds cycle 0,1,2.
    for (int i = 0; i < DEPTH; i++) begin
      alloc_valid = 1; alloc_kind = 2'(i % 3); alloc_dest = DEST_W'(100 + i);
      @(negedge clk);
      chk("R2", "alloc_tag during fill", alloc_tag, i);
      chk("R3", "ready during fill", alloc_ready, 1);
      nxt();
    end
    alloc_valid = 1; alloc_kind = 2'd2; alloc_dest = DEST_W'(999);
    @(negedge clk);
    chk("R3", "ready when full", alloc_ready, 0);
    nxt();

    lk_tag = 3;
    @(negedge clk);
    chk("R5", "hit on unfinished", lk_hit, 0);
    nxt();

    // Finish younger slots first: head stays blocked.
    for (int i = DEPTH - 1; i >= 1; i--) begin
      wb_valid = 1; wb_tag = TAG_W'(i); wb_value = val_of(i);
      @(negedge clk);
      chk("R6", "no retire while head unfinished", {cm_valid, exc_take}, 0);
      nxt();
    end
    for (int t = 0; t < DEPTH; t++) begin
      lk_tag = TAG_W'(t); #1;
      chk("R5", "lookup hit", lk_hit, (t != 0) ? 1 : 0);
      chk("R5", "lookup value", lk_value, (t != 0) ? val_of(t) : 0);
    end
    @(negedge clk);
    chk("R6", "still blocked", cm_valid, 0);
    nxt();

    wb_valid = 1; wb_tag = 0; wb_value = val_of(0);
    nxt();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk("R6", "retire fires", cm_valid, 1);
      chk("R6", "retire order", cm_tag, i);
      chk("R7", "reg write", cm_reg_we, (i % 3 == 0) ? 1 : 0);
      chk("R7", "mem write", cm_mem_we, (i % 3 == 1) ? 1 : 0);
      chk("R3", "dest not overwritten", cm_dest, 100 + i);
      chk("R7", "value", cm_value, val_of(i));
      nxt();
    end
    @(negedge clk);
    chk("R6", "empty after drain", cm_valid, 0);
    chk("R2", "tag wraps to 0", alloc_tag, 0);
    chk("R3", "ready after drain", alloc_ready, 1);

    // Claim and retire in the same cycle.
    alloc_valid = 1; alloc_kind = 0; alloc_dest = DEST_W'(200);
    nxt();
    wb_valid = 1; wb_tag = 0; wb_value = 55;
    nxt();
    alloc_valid = 1; alloc_kind = 0; alloc_dest = DEST_W'(201);
    @(negedge clk);
    chk("R8", "retire during claim", cm_valid, 1);
    chk("R8", "claim tag", alloc_tag, 1);
    nxt();
    n_acc = 0;
    for (int k = 0; k < 10; k++) begin
      alloc_valid = 1; alloc_kind = 0; alloc_dest = DEST_W'(300 + k);
      @(negedge clk);
      if (alloc_ready) n_acc++;
      nxt();
    end
    chk("R8", "free slots after claim+retire", n_acc, DEPTH - 1);

    // Flush while head finished and a claim pending.
    wb_valid = 1; wb_tag = 1; wb_value = 9;
    nxt();
    flush = 1; alloc_valid = 1;
    @(negedge clk);
    chk("R9", "retire masked by flush", {cm_valid, cm_reg_we, cm_mem_we}, 0);
    nxt();
    lk_tag = 1;
    @(negedge clk);
    chk("R9", "ready after flush", alloc_ready, 1);
    chk("R9", "tag after flush", alloc_tag, 0);
    chk("R9", "old slot gone", lk_hit, 0);
    chk("R9", "no retire after flush", cm_valid, 0);

    // Result to an unoccupied slot is ignored.
    wb_valid = 1; wb_tag = 3; wb_value = 77;
    nxt();
    for (int i = 0; i < 4; i++) begin
      alloc_valid = 1; alloc_kind = 0; alloc_dest = DEST_W'(i);
      nxt();
    end
    lk_tag = 3;
    @(negedge clk);
    chk("R4", "stray result ignored", lk_hit, 0);
    chk("R4", "stray value ignored", lk_value, 0);
    flush = 1;
    nxt();

    // Fault in a younger slot; older retires first.
    for (int i = 0; i < 3; i++) begin
      alloc_valid = 1; alloc_kind = 0; alloc_dest = DEST_W'(400 + i);
      nxt();
    end
    wb_valid = 1; wb_tag = 2; wb_value = 2;
    nxt();
    wb_valid = 1; wb_tag = 1; wb_value = 1; wb_exc = 1;
    @(negedge clk);
    chk("R11", "no fault action off head", exc_take, 0);
    nxt();
    wb_valid = 1; wb_tag = 0; wb_value = 32'h10;
    nxt();
    @(negedge clk);
    chk("R11", "older retires", cm_reg_we, 1);
    chk("R11", "older tag", cm_tag, 0);
    chk("R11", "no fault yet", exc_take, 0);
    nxt();
    alloc_valid = 1; alloc_dest = DEST_W'(500);
    @(negedge clk);
    chk("R10", "fault taken", exc_take, 1);
    chk("R10", "fault tag", cm_tag, 1);
    chk("R10", "no write on fault", {cm_valid, cm_reg_we, cm_mem_we}, 0);
    nxt();
    lk_tag = 2;
    @(negedge clk);
    chk("R10", "window empty", {cm_valid, exc_take}, 0);
    chk("R10", "tag reset", alloc_tag, 0);
    chk("R10", "younger discarded", lk_hit, 0);
    chk("R10", "ready", alloc_ready, 1);
    nxt();
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule